// File: doc/BRIEF.md
# Two-Level Debug Trigger Sequencer

This block turns the per-cycle match flags from a debug unit's breakpoint comparators into trigger events. Two 32-bit definition words are used, and each is held outside the block. Each word carries a first-level half in bits 15..0 and a second-level half in bits 31..16. A half names the condition types that must match: data lanes, address modes and program counter. If any second-level half has a condition, the trigger needs two levels. The first-level match arms the sequencer, and a later second-level match completes the trigger. If no second-level half has a condition, the first-level match completes the trigger on its own.

When the trigger completes, the block always reports the event on its status output. It can also pulse a halt request or a debug-interrupt request, as the response field in bits 31..30 of the definition words selects. A trigger fires once. Any write strobe on the definition words rearms the sequencer from idle. All outputs are registered and change on the clock edge that samples the matching flags.

Top module: `trig_sequencer`

## Requirements
- R1: Each half has the layout: enable at bit 13, data lane enables at 12..6 (bit 6+k selects lane_hit[k] of its bank), data invert at 5, address mode enables at 4..2 (bit 2+k selects addr_hit[k]), PC enable at 1 and PC invert at 0. The first-level half is bits 15..0 and the second-level half is bits 31..16. A half matches when at least one condition type is enabled and every enabled type is met in the same cycle. The data type is met when any enabled lane hits. The address type is met when any enabled mode hits. The PC type is met by pc_hit of the bank.
- R2: The data invert bit inverts every lane flag before the lane enables are applied. The PC invert bit inverts the PC flag.
- R3: Definition word n is evaluated against bank n of the hit inputs, where bank n is lane_hit[7n+6:7n], addr_hit[3n+2:3n] and pc_hit[n]. A level fires when the half of either word matches. A half with no condition enabled never matches.
- R4: Triggering is on only while bit 13 or bit 29 of either word is set. When it is off, the sequencer returns to idle and produces no event.
- R5: In two-level mode, a first-level match while idle sets trig_status to 01 for one cycle and arms the sequencer. A second-level match in the same cycle is ignored. A second-level match in a later cycle completes the trigger.
- R6: When no second-level half has a condition enabled, a first-level match while idle completes the trigger directly.
- R7: On completion, trig_status is 10 for one cycle for every response. The response code in bits 31..30 works as follows: 01 in either word pulses halt_req. Otherwise 10 in either word pulses dbg_irq. Codes 00 and 11 report only.
- R8: The halt and interrupt requests last one cycle. After completion, no further event is produced until a write strobe.
- R9: A cycle with def_wr high returns the sequencer to idle, and the next cycle shows trig_status 00 with no requests.
- R10: Under synchronous reset, the outputs are 00, 0 and 0, and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| def0_word | input | 32 | Definition word 0 |
| def1_word | input | 32 | Definition word 1, the extended one |
| def_wr | input | 1 | Strobe: a definition word was written |
| lane_hit | input | 14 | Data lane match flags, 7 per bank |
| addr_hit | input | 6 | Address mode match flags, 3 per bank |
| pc_hit | input | 2 | PC region match flag, 1 per bank |
| trig_status | output | 2 | 00 none, 01 first level armed, 10 trigger complete |
| halt_req | output | 1 | One-cycle halt request |
| dbg_irq | output | 1 | One-cycle debug interrupt request |

## Verification
The assertions check properties on every cycle. Halt and interrupt requests never coincide, and each appears only alongside a completion status. Both requests last one cycle. The reserved status code never appears. A write strobe or a cleared enable always gives a quiet next cycle. Only the bench scenarios can show that the events themselves are correct. These cover the condition matching with its inversions, the choice of bank, arming before completion, single-level completion, priority among responses, and the one-shot behaviour until rearm. The bench compares each of these against a reference model driven by random definition words and random hit patterns.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int NUM_DEFS  = 2;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int LANES     = 7;
    localparam int AMODES    = 3;
    localparam int CFG_W     = LANES + AMODES + 4;
    localparam int RESP_LSB  = WORD_W - 2;

    typedef struct packed {
        logic             en;
        logic [LANES-1:0] lanes;
        logic             dinv;
        logic [AMODES-1:0] amode;
        logic             pc_en;
        logic             pc_inv;
    } half_cfg_t;

    typedef struct packed {
        logic [LANES-1:0]  lane;
        logic [AMODES-1:0] amode;
        logic              pc;
    } bank_hit_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_ARMED = 2'b01,
        SQ_FIRED = 2'b10
    } seq_state_e;

    typedef enum logic [1:0] {
        TS_NONE  = 2'b00,
        TS_ARMED = 2'b01,
        TS_DONE  = 2'b10
    } trig_status_e;

    typedef enum logic [1:0] {
        RSP_REPORT = 2'b00,
        RSP_HALT   = 2'b01,
        RSP_IRQ    = 2'b10,
        RSP_RSVD   = 2'b11
    } resp_e;

    function automatic logic cfg_any(input half_cfg_t c);
        return (|c.lanes) | (|c.amode) | c.pc_en;
    endfunction
endpackage

// File: rtl/trig_half_match.sv
module trig_half_match
    import trig_pkg::*;
(
    input  half_cfg_t cfg,
    input  bank_hit_t hit,
    output logic      match,
    output logic      configured,
    output logic      enable_bit
);
    logic data_on, addr_on;
    logic data_ok, addr_ok, pc_ok;

    always_comb begin
        data_on    = |cfg.lanes;
        addr_on    = |cfg.amode;
        data_ok    = |(cfg.lanes & (hit.lane ^ {LANES{cfg.dinv}}));
        addr_ok    = |(cfg.amode & hit.amode);
        pc_ok      = hit.pc ^ cfg.pc_inv;
        configured = cfg_any(cfg);
        match      = configured
                   & (~data_on   | data_ok)
                   & (~addr_on   | addr_ok)
                   & (~cfg.pc_en | pc_ok);
        enable_bit = cfg.en;
    end
endmodule

// File: rtl/trig_level_eval.sv
module trig_level_eval
    import trig_pkg::*;
#(
    parameter int N = NUM_DEFS
) (
    input  half_cfg_t [N-1:0] cfgs,
    input  bank_hit_t [N-1:0] hits,
    output logic              level_fire,
    output logic              level_cfg,
    output logic              level_en
);
    logic [N-1:0] m, c, e;

    for (genvar g = 0; g < N; g++) begin : g_half
        trig_half_match u_half (
            .cfg        (cfgs[g]),
            .hit        (hits[g]),
            .match      (m[g]),
            .configured (c[g]),
            .enable_bit (e[g])
        );
    end

    assign level_fire = |m;
    assign level_cfg  = |c;
    assign level_en   = |e;
endmodule

// File: rtl/trig_resp_sel.sv
module trig_resp_sel
    import trig_pkg::*;
#(
    parameter int N = NUM_DEFS
) (
    input  logic [N-1:0][1:0] codes,
    output resp_e             resp
);
    logic any_halt, any_irq;

    always_comb begin
        any_halt = 1'b0;
        any_irq  = 1'b0;
        for (int i = 0; i < N; i++) begin
            any_halt |= (codes[i] == RSP_HALT);
            any_irq  |= (codes[i] == RSP_IRQ);
        end
        if (any_halt)     resp = RSP_HALT;
        else if (any_irq) resp = RSP_IRQ;
        else              resp = RSP_REPORT;
    end
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
    import trig_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         def_wr,
    input  logic         glob_en,
    input  logic         l1_fire,
    input  logic         l2_fire,
    input  logic         l2_cfg,
    input  resp_e        resp,
    output trig_status_e status,
    output logic         halt_req,
    output logic         dbg_irq
);
    seq_state_e state;
    logic       active, arm, complete;

    always_comb begin
        active   = glob_en & ~def_wr;
        arm      = active & (state == SQ_IDLE) & l1_fire & l2_cfg;
        complete = active & (((state == SQ_IDLE) & l1_fire & ~l2_cfg) |
                             ((state == SQ_ARMED) & l2_fire));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            status   <= TS_NONE;
            halt_req <= 1'b0;
            dbg_irq  <= 1'b0;
        end else begin
            status   <= TS_NONE;
            halt_req <= 1'b0;
            dbg_irq  <= 1'b0;
            if (!active) begin
                state <= SQ_IDLE;
            end else if (arm) begin
                state  <= SQ_ARMED;
                status <= TS_ARMED;
            end else if (complete) begin
                state    <= SQ_FIRED;
                status   <= TS_DONE;
                halt_req <= (resp == RSP_HALT);
                dbg_irq  <= (resp == RSP_IRQ);
            end
        end
    end

    // R7
    resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(halt_req && dbg_irq));
    // R7
    req_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_req || dbg_irq) |-> status == TS_DONE);
    // R8
    halt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> !halt_req);
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_irq |=> !dbg_irq);
    // R9
    wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        def_wr |=> (status == TS_NONE && !halt_req && !dbg_irq));
    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> status == TS_NONE);
    // R5
    no_rsvd_status_chk: assert property (@(posedge clk) disable iff (rst)
        status != 2'b11);
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
    import trig_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WORD_W-1:0]           def0_word,
    input  logic [WORD_W-1:0]           def1_word,
    input  logic                        def_wr,
    input  logic [NUM_DEFS*LANES-1:0]   lane_hit,
    input  logic [NUM_DEFS*AMODES-1:0]  addr_hit,
    input  logic [NUM_DEFS-1:0]         pc_hit,
    output logic [1:0]                  trig_status,
    output logic                        halt_req,
    output logic                        dbg_irq
);
    logic [NUM_DEFS-1:0][WORD_W-1:0] defs;
    half_cfg_t [NUM_DEFS-1:0]        cfg_l1, cfg_l2;
    bank_hit_t [NUM_DEFS-1:0]        hits;
    logic [NUM_DEFS-1:0][1:0]        resp_codes;
    logic [NUM_DEFS-1:0]             unused_bits;

    assign defs[0] = def0_word;
    assign defs[1] = def1_word;

    for (genvar g = 0; g < NUM_DEFS; g++) begin : g_bank
        assign cfg_l1[g]      = half_cfg_t'(defs[g][CFG_W-1:0]);
        assign cfg_l2[g]      = half_cfg_t'(defs[g][HALF_W+CFG_W-1:HALF_W]);
        assign resp_codes[g]  = defs[g][RESP_LSB+1:RESP_LSB];
        assign unused_bits[g] = ^defs[g][HALF_W-1:CFG_W];
        assign hits[g].lane   = lane_hit[g*LANES +: LANES];
        assign hits[g].amode  = addr_hit[g*AMODES +: AMODES];
        assign hits[g].pc     = pc_hit[g];
    end

    logic  l1_fire, l1_cfg, l1_en;
    logic  l2_fire, l2_cfg, l2_en;
    resp_e resp;
    trig_status_e status;

    trig_level_eval #(.N(NUM_DEFS)) u_lvl1 (
        .cfgs(cfg_l1), .hits(hits),
        .level_fire(l1_fire), .level_cfg(l1_cfg), .level_en(l1_en)
    );

    trig_level_eval #(.N(NUM_DEFS)) u_lvl2 (
        .cfgs(cfg_l2), .hits(hits),
        .level_fire(l2_fire), .level_cfg(l2_cfg), .level_en(l2_en)
    );

    trig_resp_sel #(.N(NUM_DEFS)) u_resp (
        .codes(resp_codes), .resp(resp)
    );

    logic unused_l1_cfg;
    assign unused_l1_cfg = l1_cfg ^ (^unused_bits);

    trig_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .def_wr   (def_wr),
        .glob_en  (l1_en | l2_en),
        .l1_fire  (l1_fire),
        .l2_fire  (l2_fire),
        .l2_cfg   (l2_cfg),
        .resp     (resp),
        .status   (status),
        .halt_req (halt_req),
        .dbg_irq  (dbg_irq)
    );

    assign trig_status = status;
endmodule

// File: tb/trig_sequencer_bench.sv
module trig_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] def0_word = '0;
    logic [31:0] def1_word = '0;
    logic        def_wr = 1'b0;
    logic [13:0] lane_hit = '0;
    logic [5:0]  addr_hit = '0;
    logic [1:0]  pc_hit = '0;
    logic [1:0]  trig_status;
    logic        halt_req, dbg_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int m_state = 0;             // 0 idle, 1 armed, 2 fired
    logic [1:0] e_status = 2'b00;
    logic       e_halt = 1'b0, e_irq = 1'b0;

    always #10 clk = ~clk;

    trig_sequencer u_trig_sequencer (
        .clk(clk), .rst(rst), .def0_word(def0_word), .def1_word(def1_word),
        .def_wr(def_wr), .lane_hit(lane_hit), .addr_hit(addr_hit), .pc_hit(pc_hit),
        .trig_status(trig_status), .halt_req(halt_req), .dbg_irq(dbg_irq)
    );

    // R1 R2: one half against one bank of flags
    function automatic bit half_hit(logic [15:0] h, logic [6:0] ln, logic [2:0] am, logic pc);
        bit dcfg = |h[12:6];
        bit acfg = |h[4:2];
        bit pcfg = h[1];
        bit dok  = |(h[12:6] & (ln ^ {7{h[5]}}));
        bit aok  = |(h[4:2] & am);
        bit pok  = pc ^ h[0];
        return (dcfg || acfg || pcfg) && (!dcfg || dok) && (!acfg || aok) && (!pcfg || pok);
    endfunction

    function automatic bit half_cfg(logic [15:0] h);
        return (|h[12:6]) || (|h[4:2]) || h[1];
    endfunction

    // R3: level across both words
    function automatic bit level_hit(int lvl);
        bit a = half_hit(lvl ? def0_word[31:16] : def0_word[15:0], lane_hit[6:0], addr_hit[2:0], pc_hit[0]);
        bit b = half_hit(lvl ? def1_word[31:16] : def1_word[15:0], lane_hit[13:7], addr_hit[5:3], pc_hit[1]);
        return a || b;
    endfunction

    task automatic model_edge();
        bit gen, l1, l2, l2c, anyh, anyi;
        e_status = 2'b00; e_halt = 1'b0; e_irq = 1'b0;
        if (rst) begin
            m_state = 0;
            return;
        end
        gen  = def0_word[13] || def0_word[29] || def1_word[13] || def1_word[29];   // R4
        l1   = level_hit(0);
        l2   = level_hit(1);
        l2c  = half_cfg(def0_word[31:16]) || half_cfg(def1_word[31:16]);
        anyh = (def0_word[31:30] == 2'b01) || (def1_word[31:30] == 2'b01);
        anyi = (def0_word[31:30] == 2'b10) || (def1_word[31:30] == 2'b10);
        if (def_wr || !gen) begin
            m_state = 0;                                                           // R9
        end else if (m_state == 0 && l1 && l2c) begin
            m_state = 1; e_status = 2'b01;                                         // R5
        end else if ((m_state == 0 && l1 && !l2c) || (m_state == 1 && l2)) begin
            m_state = 2; e_status = 2'b10;                                         // R6 R7
            e_halt = anyh;
            e_irq  = !anyh && anyi;
        end
    endtask

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp(tag, "trig_status", 32'(trig_status), 32'(e_status));
        cmp(tag, "halt_req",    32'(halt_req),    32'(e_halt));
        cmp(tag, "dbg_irq",     32'(dbg_irq),     32'(e_irq));
    endtask

    task automatic hits(logic [13:0] l, logic [5:0] a, logic [1:0] p);
        lane_hit = l; addr_hit = a; pc_hit = p;
    endtask

    task automatic write_defs(logic [31:0] d0, logic [31:0] d1);
        hits('0, '0, '0);
        def0_word = d0; def1_word = d1; def_wr = 1'b1;
        step("R9");
        def_wr = 1'b0;
    endtask

    function automatic logic [15:0] rand_half();
        logic [15:0] h = '0;
        h[13] = ($urandom % 4) != 0;
        if ($urandom % 3 != 0) h[6 + ($urandom % 7)] = 1'b1;
        h[5] = ($urandom % 4) == 0;
        if ($urandom % 3 != 0) h[2 + ($urandom % 3)] = 1'b1;
        h[1] = $urandom % 2;
        h[0] = ($urandom % 4) == 0;
        return h;
    endfunction

    function automatic logic [31:0] rand_word();
        logic [15:0] up = ($urandom % 3 == 0) ? 16'h0 : rand_half();
        up[15:14] = 2'($urandom);
        return {up, rand_half()};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7091));
        // R10: reset state
        rst = 1'b1;
        step("R10");
        step("R10");
        rst = 1'b0;

        // R6 R7: single level, halt response
        write_defs(32'h4000_2002, 32'h0);
        hits('0, '0, 2'b01); step("R6");
        step("R8");                       // still hitting: no new event
        step("R8");

        // R5: two-level, same-cycle second level ignored, later completes with irq
        write_defs(32'hA004_2002, 32'h0);
        hits('0, 6'b000001, 2'b01); step("R5");
        hits('0, '0, '0);           step("R5");
        hits('0, 6'b000001, '0);    step("R5");
        step("R8");

        // R9: write while armed returns to idle
        write_defs(32'hA004_2002, 32'h0);
        hits('0, '0, 2'b01);        step("R5");
        write_defs(32'hA004_2002, 32'h0);
        hits('0, 6'b000001, '0);    step("R9");

        // R7: reserved code reports only; halt wins over irq
        write_defs(32'hC000_2002, 32'h0);
        hits('0, '0, 2'b01); step("R7");
        write_defs(32'h4000_2002, 32'h8000_0000);
        hits('0, '0, 2'b01); step("R7");
        write_defs(32'h8000_2002, 32'h0);
        hits('0, '0, 2'b01); step("R7");

        // R4: no enable bit, then enable from the other word's upper half
        write_defs(32'h0000_0002, 32'h0);
        hits('0, '0, 2'b01); step("R4");
        write_defs(32'h0000_0002, 32'h2000_0000);
        hits('0, '0, 2'b01); step("R4");

        // R2: data invert on lane 0
        write_defs(32'h0000_2060, 32'h0);
        hits(14'h1, '0, '0); step("R2");
        hits(14'h0, '0, '0); step("R2");

        // R3: bank 1 drives word 1; unconfigured word 0 never matches
        write_defs(32'h0000_2000, 32'h0000_0002);
        hits('0, '0, 2'b01); step("R3");
        hits('0, '0, 2'b10); step("R3");

        // R1: both enabled types must match in the same cycle
        write_defs(32'h0000_2006, 32'h0);
        hits('0, '0, 2'b01);        step("R1");
        hits('0, 6'b000001, 2'b00); step("R1");
        hits('0, 6'b000001, 2'b01); step("R1");

        // random mix, R1 R2 R3 R5 R6 R7 R8 covered by the model
        for (int i = 0; i < 4000; i++) begin
            if (i % 40 == 0) begin
                write_defs(rand_word(), rand_word());
            end else begin
                hits(14'($urandom), 6'($urandom), 2'($urandom));
                step("R5");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule